// File: doc/BRIEF.md
# Wake-on-LAN Event Controller

This block decides when an Ethernet receiver should wake its host. A 16-bit management port writes a configuration register, a wake-control register, a sticky status register and a filter register. It also writes three station-address words. Writes to the address words always land in shadow registers. They are copied into a 48-bit receive-address pair only while the configuration enable bit is set. The write of the last word then marks the address valid and turns wake-up on by itself. For that reason the enable must be written before the address.

Two detectors feed the wake logic. The first is a magic-packet matcher, which is a small state machine fed by the received-byte stream. The second is an edge detector on a link-status input. When an enabled event occurs, the block sets a sticky status bit and raises `wake_req` for one clock.

The matcher has four states:
- HUNT: no sync byte seen yet.
- SYNC: counting consecutive 0xFF bytes.
- ADDR: comparing address copies.
- DONE: a full pattern has been seen and the matcher waits for the frame end.

Its transitions are:
- *sync-start*: HUNT→SYNC on 0xFF.
- *sync-break*: SYNC→HUNT on a non-0xFF byte before the run is long enough.
- *addr-enter*: SYNC→ADDR on address byte 0 after at least six 0xFF bytes.
- *resync*: ADDR→SYNC on a mismatching 0xFF.
- *drop*: ADDR→HUNT on any other mismatch.
- *complete*: ADDR→DONE after the sixteenth copy.
- *frame-reset*: any state→HUNT on start or end of frame.

Top module: `wol_wake_ctrl`

## Requirements
- R1: Bit 10 of the configuration register (address 26) is the configuration enable. The register reads back as written.
- R2: Words written to addresses 27, 28 and 29 always read back from their shadows. While the configuration enable is set, they also load `rx_addr_lo[15:0]`, `rx_addr_lo[31:16]` and `rx_addr_hi[15:0]` one cycle after the write.
- R3: A write to address 29 while the configuration enable is set sets `rx_addr_hi[31]` (address valid) and bit 0 (wake enable) of the control register (address 16).
- R4: A write to address 27, 28 or 29 while the configuration enable is clear leaves `rx_addr_lo`, `rx_addr_hi` and the control register unchanged.
- R5: A magic packet consists of at least six consecutive 0xFF bytes followed by sixteen consecutive copies of the station address, anywhere in a frame. The station address is sent byte 0 first, where byte k is bits [8k+7:8k] of {`rx_addr_hi[15:0]`, `rx_addr_lo`}. A mismatching 0xFF byte starts a new sync run. Fewer than sixteen copies do not match.
- R6: A start-of-frame strobe restarts the matcher. A frame whose end strobe carries `rx_err` produces no match.
- R7: A match at an error-free frame end, with wake enable and address valid both set, sets status bit 1 (address 17). It also pulses `wake_req` in the next cycle.
- R8: A change on `link_up` sets status bit 0 and pulses `wake_req` only when control bit 0 and control bit 4 are both set.
- R9: While control bit 5 is set and either control bit 0 or control bit 4 is clear, bit 0 of the filter register (address 18) reads 0. Otherwise it reads back as written.
- R10: Status bits are sticky. Writing 1 to a status bit clears it, writing 0 has no effect, and a new event wins over a clear in the same cycle.
- R11: `wake_req` is high for exactly one cycle per event. No event occurs while wake enable is clear.
- R12: Wake enable is cleared by a software write of 0 to control bit 0 or by a `nvm_reload` pulse. The pulse wins over any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_addr | input | 5 | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Read data for `mgmt_addr` (combinational) |
| rx_valid | input | 1 | `rx_byte` carries a received byte |
| rx_byte | input | 8 | Received byte |
| rx_sof | input | 1 | Start-of-frame strobe |
| rx_eof | input | 1 | End-of-frame strobe |
| rx_err | input | 1 | Frame error, qualified by `rx_eof` |
| link_up | input | 1 | Link status |
| nvm_reload | input | 1 | Reload pulse that clears wake enable |
| rx_addr_lo | output | 32 | Receive address, low 32 bits |
| rx_addr_hi | output | 32 | Bit 31: address valid; bits 15:0: receive address high word |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The hardest case to reach from the ports is the *resync* transition. It needs a 0xFF byte to break an address run that has already started, while that same byte also begins the sync run that leads to a match. The bench sends six 0xFF bytes and two correct address bytes, then a second full magic pattern, and expects a wake at the frame end. Related cases keep the address run short by one copy, or cut it with a start-of-frame strobe, and both must give no wake.

// File: rtl/wol_pkg.sv
package wol_pkg;
    localparam int MGMT_DW = 16;
    localparam int MGMT_AW = 5;

    localparam logic [MGMT_AW-1:0] A_CTRL = 5'd16;
    localparam logic [MGMT_AW-1:0] A_STAT = 5'd17;
    localparam logic [MGMT_AW-1:0] A_FILT = 5'd18;
    localparam logic [MGMT_AW-1:0] A_CFG  = 5'd26;
    localparam logic [MGMT_AW-1:0] A_W0   = 5'd27;
    localparam logic [MGMT_AW-1:0] A_W1   = 5'd28;
    localparam logic [MGMT_AW-1:0] A_W2   = 5'd29;

    localparam int CFG_EN_BIT = 10;
    localparam int C_WAKE     = 0;
    localparam int C_LINK     = 4;
    localparam int C_GATE     = 5;
    localparam int S_LINK     = 0;
    localparam int S_MAGIC    = 1;

    typedef enum logic [1:0] {
        M_HUNT = 2'd0,
        M_SYNC = 2'd1,
        M_ADDR = 2'd2,
        M_DONE = 2'd3
    } match_state_t;
endpackage

// File: rtl/wol_magic_match.sv
module wol_magic_match
    import wol_pkg::*;
#(
    parameter int SYNC_LEN   = 6,
    parameter int REPS       = 16,
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic                    rx_err,
    input  logic [8*ADDR_BYTES-1:0] station,
    output logic                    hit
);
    localparam int MAXC = (SYNC_LEN > ADDR_BYTES) ? SYNC_LEN : ADDR_BYTES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int RW   = $clog2(REPS);
    localparam logic [CW-1:0] SYNC_FULL = CW'(SYNC_LEN);
    localparam logic [CW-1:0] BYTE_LAST = CW'(ADDR_BYTES - 1);
    localparam logic [RW-1:0] REP_LAST  = RW'(REPS - 1);

    match_state_t  state_q, state_d, st;
    logic [CW-1:0] cnt_q, cnt_d, c;
    logic [RW-1:0] rep_q, rep_d, r;
    logic [7:0]    exp_byte;
    logic          is_ff;

    // frame start overrides the stored position
    always_comb begin
        st = rx_sof ? M_HUNT : state_q;
        c  = rx_sof ? '0 : cnt_q;
        r  = rx_sof ? '0 : rep_q;
    end

    always_comb begin
        exp_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++)
            if (c == CW'(k)) exp_byte = station[8*k +: 8];
    end

    assign is_ff = (rx_byte == 8'hFF);

    // next-state logic
    always_comb begin
        state_d = st;
        cnt_d   = c;
        rep_d   = r;
        if (rx_eof) begin
            state_d = M_HUNT;
            cnt_d   = '0;
            rep_d   = '0;
        end else if (rx_valid) begin
            unique case (st)
                M_HUNT: if (is_ff) begin
                    state_d = M_SYNC;             // sync-start
                    cnt_d   = CW'(1);
                end
                M_SYNC: begin
                    if (c == SYNC_FULL && rx_byte == station[7:0]) begin
                        state_d = M_ADDR;         // addr-enter
                        cnt_d   = CW'(1);
                        rep_d   = '0;
                    end else if (is_ff) begin
                        cnt_d = (c == SYNC_FULL) ? c : c + CW'(1);
                    end else begin
                        state_d = M_HUNT;         // sync-break
                        cnt_d   = '0;
                    end
                end
                M_ADDR: begin
                    if (rx_byte == exp_byte) begin
                        if (c == BYTE_LAST) begin
                            cnt_d = '0;
                            if (r == REP_LAST) state_d = M_DONE;   // complete
                            else rep_d = r + RW'(1);
                        end else begin
                            cnt_d = c + CW'(1);
                        end
                    end else if (is_ff) begin
                        state_d = M_SYNC;         // resync
                        cnt_d   = CW'(1);
                        rep_d   = '0;
                    end else begin
                        state_d = M_HUNT;         // drop
                        cnt_d   = '0;
                        rep_d   = '0;
                    end
                end
                M_DONE: state_d = M_DONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= M_HUNT;
            cnt_q   <= '0;
            rep_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rep_q   <= rep_d;
        end
    end

    // output: match is reported at a clean frame end
    always_comb begin
        hit = rx_eof && !rx_err && (st == M_DONE);
    end
endmodule

// File: rtl/wol_link_det.sv
module wol_link_det (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    output logic link_chg
);
    logic link_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) link_q <= 1'b0;
        else        link_q <= link_up;
    end

    assign link_chg = link_up ^ link_q;
endmodule

// File: rtl/wol_regs.sv
module wol_regs
    import wol_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mgmt_we,
    input  logic [MGMT_AW-1:0] mgmt_addr,
    input  logic [MGMT_DW-1:0] mgmt_wdata,
    output logic [MGMT_DW-1:0] mgmt_rdata,
    input  logic               magic_hit,
    input  logic               link_chg,
    input  logic               nvm_reload,
    output logic [31:0]        rx_addr_lo,
    output logic [31:0]        rx_addr_hi,
    output logic               wake_req,
    output logic [MGMT_DW-1:0] ctrl_o,
    output logic [MGMT_DW-1:0] stat_o,
    output logic               cfg_en
);
    logic [MGMT_DW-1:0] cfg_q, w0_q, w1_q, w2_q, ctrl_q, stat_q, filt_q;
    logic [31:0]        lo_q;
    logic [15:0]        hi_q;
    logic               valid_q;
    logic               wr_cfg, wr_w0, wr_w1, wr_w2, wr_ctrl, wr_stat, wr_filt;
    logic               magic_evt, link_evt, filt_mask;
    logic [MGMT_DW-1:0] set_vec, clr_vec;

    assign wr_cfg  = mgmt_we && (mgmt_addr == A_CFG);
    assign wr_w0   = mgmt_we && (mgmt_addr == A_W0);
    assign wr_w1   = mgmt_we && (mgmt_addr == A_W1);
    assign wr_w2   = mgmt_we && (mgmt_addr == A_W2);
    assign wr_ctrl = mgmt_we && (mgmt_addr == A_CTRL);
    assign wr_stat = mgmt_we && (mgmt_addr == A_STAT);
    assign wr_filt = mgmt_we && (mgmt_addr == A_FILT);

    assign cfg_en    = cfg_q[CFG_EN_BIT];
    assign magic_evt = magic_hit && ctrl_q[C_WAKE] && valid_q;
    assign link_evt  = link_chg && ctrl_q[C_WAKE] && ctrl_q[C_LINK];
    assign filt_mask = ctrl_q[C_GATE] && !(ctrl_q[C_WAKE] && ctrl_q[C_LINK]);

    always_comb begin
        set_vec          = '0;
        set_vec[S_LINK]  = link_evt;
        set_vec[S_MAGIC] = magic_evt;
        clr_vec          = wr_stat ? mgmt_wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            w0_q     <= '0;
            w1_q     <= '0;
            w2_q     <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            valid_q  <= 1'b0;
            ctrl_q   <= '0;
            stat_q   <= '0;
            filt_q   <= '0;
            wake_req <= 1'b0;
        end else begin
            if (wr_cfg)  cfg_q  <= mgmt_wdata;
            if (wr_filt) filt_q <= mgmt_wdata;
            if (wr_ctrl) ctrl_q <= mgmt_wdata;
            if (wr_w0) begin
                w0_q <= mgmt_wdata;
                if (cfg_en) lo_q[15:0] <= mgmt_wdata;
            end
            if (wr_w1) begin
                w1_q <= mgmt_wdata;
                if (cfg_en) lo_q[31:16] <= mgmt_wdata;
            end
            if (wr_w2) begin
                w2_q <= mgmt_wdata;
                if (cfg_en) begin
                    hi_q           <= mgmt_wdata;
                    valid_q        <= 1'b1;
                    ctrl_q[C_WAKE] <= 1'b1;
                end
            end
            if (nvm_reload) ctrl_q[C_WAKE] <= 1'b0;
            stat_q   <= (stat_q & ~clr_vec) | set_vec;
            wake_req <= magic_evt || link_evt;
        end
    end

    always_comb begin
        case (mgmt_addr)
            A_CFG:   mgmt_rdata = cfg_q;
            A_W0:    mgmt_rdata = w0_q;
            A_W1:    mgmt_rdata = w1_q;
            A_W2:    mgmt_rdata = w2_q;
            A_CTRL:  mgmt_rdata = ctrl_q;
            A_STAT:  mgmt_rdata = stat_q;
            A_FILT:  mgmt_rdata = {filt_q[MGMT_DW-1:1], filt_q[0] && !filt_mask};
            default: mgmt_rdata = '0;
        endcase
    end

    assign rx_addr_lo = lo_q;
    assign rx_addr_hi = {valid_q, 15'b0, hi_q};
    assign ctrl_o     = ctrl_q;
    assign stat_o     = stat_q;
endmodule

// File: rtl/wol_wake_ctrl.sv
module wol_wake_ctrl
    import wol_pkg::*;
#(
    parameter int SYNC_LEN = 6,
    parameter int REPS     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mgmt_we,
    input  logic [MGMT_AW-1:0] mgmt_addr,
    input  logic [MGMT_DW-1:0] mgmt_wdata,
    output logic [MGMT_DW-1:0] mgmt_rdata,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic               rx_err,
    input  logic               link_up,
    input  logic               nvm_reload,
    output logic [31:0]        rx_addr_lo,
    output logic [31:0]        rx_addr_hi,
    output logic               wake_req
);
    localparam int ADDR_BYTES = 3 * MGMT_DW / 8;

    logic               magic_hit_w, link_chg_w, cfg_en_w;
    logic [MGMT_DW-1:0] ctrl_w, stat_w;

    wol_magic_match #(
        .SYNC_LEN  (SYNC_LEN),
        .REPS      (REPS),
        .ADDR_BYTES(ADDR_BYTES)
    ) match_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .rx_sof  (rx_sof),
        .rx_eof  (rx_eof),
        .rx_err  (rx_err),
        .station ({rx_addr_hi[15:0], rx_addr_lo}),
        .hit     (magic_hit_w)
    );

    wol_link_det link_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .link_chg(link_chg_w)
    );

    wol_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mgmt_we   (mgmt_we),
        .mgmt_addr (mgmt_addr),
        .mgmt_wdata(mgmt_wdata),
        .mgmt_rdata(mgmt_rdata),
        .magic_hit (magic_hit_w),
        .link_chg  (link_chg_w),
        .nvm_reload(nvm_reload),
        .rx_addr_lo(rx_addr_lo),
        .rx_addr_hi(rx_addr_hi),
        .wake_req  (wake_req),
        .ctrl_o    (ctrl_w),
        .stat_o    (stat_w),
        .cfg_en    (cfg_en_w)
    );
endmodule

// File: rtl/wol_wake_ctrl_chk.sv
module wol_wake_ctrl_chk
    import wol_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               mgmt_we,
    input logic [MGMT_AW-1:0] mgmt_addr,
    input logic [MGMT_DW-1:0] mgmt_rdata,
    input logic               nvm_reload,
    input logic [31:0]        rx_addr_lo,
    input logic [31:0]        rx_addr_hi,
    input logic               wake_req,
    input logic [MGMT_DW-1:0] ctrl_w,
    input logic [MGMT_DW-1:0] stat_w,
    input logic               cfg_en_w,
    input logic               magic_hit_w,
    input logic               link_chg_w
);
    assert_last_word_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_we && mgmt_addr == A_W2 && cfg_en_w && !nvm_reload)
            |=> (rx_addr_hi[31] && ctrl_w[C_WAKE]));

    assert_shadow_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_we && !cfg_en_w && (mgmt_addr == A_W0 || mgmt_addr == A_W1 || mgmt_addr == A_W2))
            |=> ($stable(rx_addr_lo) && $stable(rx_addr_hi)));

    assert_wake_has_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (stat_w[S_LINK] || stat_w[S_MAGIC]));

    assert_link_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_chg_w && !(ctrl_w[C_WAKE] && ctrl_w[C_LINK]) && !(magic_hit_w && ctrl_w[C_WAKE]))
            |=> !wake_req);

    assert_filter_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_addr == A_FILT && ctrl_w[C_GATE] && !(ctrl_w[C_WAKE] && ctrl_w[C_LINK]))
            |-> !mgmt_rdata[0]);

    assert_wake_from_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(magic_hit_w || link_chg_w));

    assert_reload_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_reload |=> !ctrl_w[C_WAKE]);
endmodule

bind wol_wake_ctrl wol_wake_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mgmt_we    (mgmt_we),
    .mgmt_addr  (mgmt_addr),
    .mgmt_rdata (mgmt_rdata),
    .nvm_reload (nvm_reload),
    .rx_addr_lo (rx_addr_lo),
    .rx_addr_hi (rx_addr_hi),
    .wake_req   (wake_req),
    .ctrl_w     (ctrl_w),
    .stat_w     (stat_w),
    .cfg_en_w   (cfg_en_w),
    .magic_hit_w(magic_hit_w),
    .link_chg_w (link_chg_w)
);

// File: tb/wol_wake_ctrl_tb.sv
module wol_wake_ctrl_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        mgmt_we = 0;
    logic [4:0]  mgmt_addr = 0;
    logic [15:0] mgmt_wdata = 0;
    logic [15:0] mgmt_rdata;
    logic        rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
    logic [7:0]  rx_byte = 0;
    logic        link_up = 0, nvm_reload = 0;
    logic [31:0] rx_addr_lo, rx_addr_hi;
    logic        wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wol_wake_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr),
        .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .link_up(link_up), .nvm_reload(nvm_reload), .rx_addr_lo(rx_addr_lo),
        .rx_addr_hi(rx_addr_hi), .wake_req(wake_req)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  a;
        logic [15:0] d;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 5'd27, 16'h2211, 16'h0000, 8'd4},   // R4: enable clear
        '{1'b1, 5'd28, 16'h4433, 16'h0000, 8'd4},
        '{1'b1, 5'd29, 16'h6655, 16'h0000, 8'd4},
        '{1'b0, 5'd27, 16'h0000, 16'h2211, 8'd2},   // R2: shadow readback
        '{1'b0, 5'd29, 16'h0000, 16'h6655, 8'd2},
        '{1'b0, 5'd16, 16'h0000, 16'h0000, 8'd4},   // R4: wake enable untouched
        '{1'b1, 5'd26, 16'h0400, 16'h0000, 8'd1},   // R1
        '{1'b0, 5'd26, 16'h0000, 16'h0400, 8'd1},
        '{1'b1, 5'd27, 16'h2211, 16'h0000, 8'd2},
        '{1'b1, 5'd28, 16'h4433, 16'h0000, 8'd2},
        '{1'b1, 5'd29, 16'h6655, 16'h0000, 8'd3},
        '{1'b0, 5'd16, 16'h0000, 16'h0001, 8'd3},   // R3: wake enable armed
        '{1'b1, 5'd16, 16'h0031, 16'h0000, 8'd8},
        '{1'b0, 5'd16, 16'h0000, 16'h0031, 8'd8},   // R8 setup
        '{1'b1, 5'd18, 16'h0001, 16'h0000, 8'd9},
        '{1'b0, 5'd18, 16'h0000, 16'h0001, 8'd9}    // R9 unmasked
    };

    localparam logic [7:0] ST [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mwrite(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        mgmt_we = 1; mgmt_addr = a; mgmt_wdata = d;
        @(negedge clk);
        mgmt_we = 0;
    endtask

    task automatic mread(input logic [4:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        mgmt_we = 0; mgmt_addr = a;
        #1 chk(tag, {16'h0, mgmt_rdata}, {16'h0, exp});
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_sof = 0; rx_valid = 1; rx_byte = b;
    endtask

    task automatic sof();
        @(negedge clk);
        rx_valid = 0; rx_sof = 1;
    endtask

    task automatic sync_run();
        for (int i = 0; i < 6; i++) put(8'hFF);
    endtask

    task automatic copies(input int n);
        for (int j = 0; j < n; j++)
            for (int k = 0; k < 6; k++) put(ST[k]);
    endtask

    // end frame and check wake pulse: high one cycle, then low
    task automatic eof(input bit err, input bit exp_wake, input string tag);
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 1; rx_err = err;
        @(negedge clk);
        rx_eof = 0; rx_err = 0;
        chk(tag, {31'h0, wake_req}, {31'h0, exp_wake});
        @(negedge clk);
        chk({tag, " pulse end R11"}, {31'h0, wake_req}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        @(negedge clk);
        chk("reset R2 addr lo", rx_addr_lo, 32'h0);
        chk("reset R3 addr hi", rx_addr_hi, 32'h0);
        chk("reset R11 wake", {31'h0, wake_req}, 32'h0);
        mread(5'd17, 16'h0000, "reset R10 status");

        for (int v = 0; v < NV; v++) begin
            if (TBL[v].we) mwrite(TBL[v].a, TBL[v].d);
            else mread(TBL[v].a, TBL[v].exp, $sformatf("table %0d R%0d", v, TBL[v].req));
        end
        chk("R2 addr lo", rx_addr_lo, 32'h44332211);
        chk("R3 addr hi valid", rx_addr_hi, 32'h80006655);

        // R5/R7: plain magic packet with junk before it
        sof(); put(8'h01); put(8'hFF); put(8'h02);
        sync_run(); copies(16);
        eof(0, 1, "R7 magic wake");
        mread(5'd17, 16'h0002, "R7 magic status");

        // R10: writing 0 to bit 1 keeps it, writing 1 clears
        mwrite(5'd17, 16'h0001);
        mread(5'd17, 16'h0002, "R10 sticky");
        mwrite(5'd17, 16'h0002);
        mread(5'd17, 16'h0000, "R10 w1c");

        // R6: errored frame
        sof(); sync_run(); copies(16);
        eof(1, 0, "R6 error frame");
        mread(5'd17, 16'h0000, "R6 status");

        // R5: resync on FF inside address run
        sof(); sync_run(); put(8'h11); put(8'h22);
        sync_run(); copies(16);
        eof(0, 1, "R5 resync");
        mwrite(5'd17, 16'h0002);

        // R5: fifteen copies only
        sof(); sync_run(); copies(15);
        eof(0, 0, "R5 short");

        // R6: start of frame mid pattern
        sof(); sync_run(); copies(8); sof(); copies(8);
        eof(0, 0, "R6 sof restart");
        mread(5'd17, 16'h0000, "R6 no status");

        // R8: link change with both bits set
        @(negedge clk); link_up = 1;
        @(negedge clk);
        chk("R8 link wake", {31'h0, wake_req}, 32'h1);
        @(negedge clk);
        chk("R11 link pulse end", {31'h0, wake_req}, 32'h0);
        mread(5'd17, 16'h0001, "R8 link status");
        mwrite(5'd17, 16'h0001);

        // R8/R9: bit 4 clear, gate set
        mwrite(5'd16, 16'h0021);
        @(negedge clk); link_up = 0;
        @(negedge clk);
        chk("R8 link gated", {31'h0, wake_req}, 32'h0);
        mread(5'd17, 16'h0000, "R8 gated status");
        mread(5'd18, 16'h0000, "R9 filter masked");
        mwrite(5'd16, 16'h0031);
        mread(5'd18, 16'h0001, "R9 filter visible");

        // R11/R12: software clears wake enable
        mwrite(5'd16, 16'h0030);
        sof(); sync_run(); copies(16);
        eof(0, 0, "R12 sw disabled");
        mread(5'd17, 16'h0000, "R11 no status");
        mwrite(5'd16, 16'h0031);
        @(negedge clk); nvm_reload = 1;
        @(negedge clk); nvm_reload = 0;
        mread(5'd16, 16'h0030, "R12 reload");

        // R4: enable cleared, address write only hits the shadow
        mwrite(5'd26, 16'h0000);
        mwrite(5'd27, 16'hAAAA);
        mwrite(5'd29, 16'hBBBB);
        chk("R4 lo kept", rx_addr_lo, 32'h44332211);
        chk("R4 hi kept", rx_addr_hi, 32'h80006655);
        mread(5'd16, 16'h0030, "R4 wake enable kept");
        mread(5'd27, 16'hAAAA, "R2 shadow updated");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule